// File: doc/BRIEF.md
# Two-Way Set-Associative Store Controller with Deferred Write-Back

This block takes store requests for a small two-way set-associative data cache and decides, in the cycle a request is offered, whether it hits or misses. It owns the per-line valid bits, modified bits and tags, and one most-recently-used bit per set. It also owns a plain register model of the line data. Each request carries its own write policy bit, which selects copy-back or write-through.

A copy-back hit writes the word into the line, marks the line modified and records the way as most recently used. A write-through hit does the same, except that it leaves the modified bit alone and also sends the word out as a single-word bus write. A write-through miss only sends that bus write and allocates nothing.

A copy-back miss picks a victim way. If the victim holds modified data, that line is parked in an eviction buffer. The block then asks a fill engine for the missing line, critical word first. The store word is merged over the critical word. Once the last beat has arrived, the line is installed as valid and modified. The parked line is offered for write-back only after the fill is done. Hits keep being served while it waits.

The controller has two states:
- `ST_IDLE` accepts requests.
- `ST_FILL` collects fill beats.

It has two transitions:
- ST_IDLE to ST_FILL, on an accepted copy-back miss.
- ST_FILL to ST_IDLE, on the last fill beat.

Top module: `cbc_store_ctrl`

## Requirements
- R1: A copy-back store that hits writes its word into the hit line and leaves that line valid and modified. It makes the hit way the most recently used way of the set. While the request is offered, req_hit is 1 and req_way gives the hit way.
- R2: On a copy-back miss the victim is an invalid way if there is one, and way 0 when both ways are invalid. req_way shows the victim while the miss is offered.
- R3: On a copy-back miss with both ways valid, the victim is the way that is not the most recently used one. After reset the most recently used way of every set is way 0.
- R4: A victim that is valid and modified is copied into the eviction buffer in the cycle the miss is accepted. flush_valid stays 0 until the fill has completed, and is 1 afterwards until flush_done is seen together with flush_valid. The buffer contents are presented as follows:
  - flush_addr is {victim tag, set index, zero word offset}.
  - Word k of the line sits at flush_line bits [k*DATA_W +: DATA_W].
- R5: Fill request and line install for a copy-back miss:
  - Accepting the miss raises fill_req for that one cycle, with fill_addr equal to the store address.
  - Fill data then arrives on WORDS cycles with fill_valid, in the order critical word, critical+1, and so on, wrapping within the line.
  - The store word replaces the critical word.
  - After the last beat the line is valid and modified with the new tag, and becomes the set's most recently used way.
- R6: From the cycle after a copy-back miss is accepted until the cycle after its last fill beat, req_ready is 0. fill_valid outside a fill has no effect.
- R7: While the eviction buffer is waiting to be written back, requests that hit are accepted. A hit may be accepted in the same cycle as flush_done.
- R8: A copy-back miss offered while the eviction buffer is full sees req_ready 0. It is accepted in the first cycle after the buffer has been released.
- R9: A write-through hit writes the word, updates the most recently used way, and leaves the modified bit unchanged. In the same cycle it raises wt_valid with wt_addr and wt_data equal to the request.
- R10: A write-through miss raises wt_valid for one cycle. It raises no fill_req and changes no line, tag or most-recently-used state.
- R11: After reset every line is invalid and the eviction buffer is empty. req_ready is 1 and fill_req, wt_valid and flush_valid are 0.

Address split, valid for every requirement above:
- The low log2(WORDS) bits of an address are the word offset.
- The next log2(SETS) bits are the set index.
- The remaining high bits are the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Store request offered |
| req_addr | input | ADDR_W | Word address of the store |
| req_data | input | DATA_W | Store data |
| req_wt | input | 1 | 1 selects write-through, 0 selects copy-back |
| req_ready | output | 1 | Request is accepted this cycle when req_valid is also 1 |
| req_hit | output | 1 | Lookup result for the offered address |
| req_way | output | 1 | Hit way on a hit, victim way on a miss |
| fill_req | output | 1 | One-cycle request for the missing line |
| fill_addr | output | ADDR_W | Address of the critical word |
| fill_valid | input | 1 | One fill beat present |
| fill_data | input | DATA_W | Fill beat data |
| wt_valid | output | 1 | Single-word bus write for a write-through store |
| wt_addr | output | ADDR_W | Address of that write |
| wt_data | output | DATA_W | Data of that write |
| flush_valid | output | 1 | Eviction buffer holds a line to write back |
| flush_addr | output | ADDR_W | Line address of the parked line |
| flush_line | output | WORDS*DATA_W | Parked line data |
| flush_done | input | 1 | Write-back taken; frees the buffer when flush_valid is 1 |

## Verification
Serving a store hit and releasing the eviction buffer can happen in the same cycle. To provoke this, the bench offers a hit while flush_valid is high and raises flush_done in that very cycle. The cycle-level reference model then expects the hit to be accepted, the line and most-recently-used state to be updated, and flush_valid to fall on the following cycle.

The bench also holds a copy-back miss against a full buffer. It expects req_ready to stay low through the release cycle and the miss to be accepted on the cycle after it.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } cbc_state_e;
endpackage

// File: rtl/cbc_tag_dir.sv
module cbc_tag_dir #(
    parameter int SETS  = 4,
    parameter int TAG_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(SETS)-1:0]   lk_idx,
    input  logic [TAG_W-1:0]          lk_tag,
    output logic                      hit,
    output logic                      hit_way,
    output logic                      vict_way,
    output logic                      vict_dirty,
    output logic [TAG_W-1:0]          vict_tag,
    input  logic                      touch_en,
    input  logic [$clog2(SETS)-1:0]   touch_idx,
    input  logic                      touch_way,
    input  logic                      dirty_en,
    input  logic                      inst_en,
    input  logic [$clog2(SETS)-1:0]   inst_idx,
    input  logic                      inst_way,
    input  logic [TAG_W-1:0]          inst_tag
);
    localparam int WAYS = 2;

    logic [SETS-1:0][WAYS-1:0]            valid_q;
    logic [SETS-1:0][WAYS-1:0]            mod_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0]                      mru_q;
    logic [WAYS-1:0]                      way_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    end

    always_comb begin
        hit     = |way_hit;
        hit_way = way_hit[1];
        if (!valid_q[lk_idx][0])      vict_way = 1'b0;
        else if (!valid_q[lk_idx][1]) vict_way = 1'b1;
        else                          vict_way = ~mru_q[lk_idx];
        vict_dirty = valid_q[lk_idx][vict_way] && mod_q[lk_idx][vict_way];
        vict_tag   = tag_q[lk_idx][vict_way];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            mod_q   <= '0;
            tag_q   <= '0;
            mru_q   <= '0;
        end else begin
            if (touch_en) begin
                mru_q[touch_idx] <= touch_way;
                if (dirty_en) mod_q[touch_idx][touch_way] <= 1'b1;
            end
            if (inst_en) begin
                valid_q[inst_idx][inst_way] <= 1'b1;
                mod_q[inst_idx][inst_way]   <= 1'b1;
                tag_q[inst_idx][inst_way]   <= inst_tag;
                mru_q[inst_idx]             <= inst_way;
            end
        end
    end

    // R1: a tag never matches in both ways of a set
    a_r1_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R5: an installed line hits on the next cycle when looked up again
    a_r5_install_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_en && lk_idx == inst_idx && lk_tag == inst_tag) |=>
        ($stable(lk_idx) && $stable(lk_tag)) |-> hit);
endmodule

// File: rtl/cbc_data_ram.sv
module cbc_data_ram #(
    parameter int SETS   = 4,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [$clog2(SETS)-1:0]    wr_idx,
    input  logic                       wr_way,
    input  logic [$clog2(WORDS)-1:0]   wr_word,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(SETS)-1:0]    rd_idx,
    input  logic                       rd_way,
    output logic [WORDS*DATA_W-1:0]    rd_line
);
    logic [SETS-1:0][1:0][WORDS-1:0][DATA_W-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx][wr_way][wr_word] <= wr_data;
    end

    assign rd_line = mem_q[rd_idx][rd_way];
endmodule

// File: rtl/cbc_evict_buf.sv
module cbc_evict_buf #(
    parameter int ADDR_W = 8,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LINE_W-1:0] load_line,
    input  logic              drain_en,
    output logic              full,
    output logic [ADDR_W-1:0] addr,
    output logic [LINE_W-1:0] line
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            addr <= '0;
            line <= '0;
        end else if (load_en) begin
            full <= 1'b1;
            addr <= load_addr;
            line <= load_line;
        end else if (drain_en) begin
            full <= 1'b0;
        end
    end

    // R4: a parked line is never overwritten before it is written back
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !full);
endmodule

// File: rtl/cbc_store_ctrl.sv
module cbc_store_ctrl
    import cbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SETS   = 4,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_data,
    input  logic                    req_wt,
    output logic                    req_ready,
    output logic                    req_hit,
    output logic                    req_way,
    output logic                    fill_req,
    output logic [ADDR_W-1:0]       fill_addr,
    input  logic                    fill_valid,
    input  logic [DATA_W-1:0]       fill_data,
    output logic                    wt_valid,
    output logic [ADDR_W-1:0]       wt_addr,
    output logic [DATA_W-1:0]       wt_data,
    output logic                    flush_valid,
    output logic [ADDR_W-1:0]       flush_addr,
    output logic [WORDS*DATA_W-1:0] flush_line,
    input  logic                    flush_done
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = WORDS * DATA_W;

    cbc_state_e state_q, state_d;

    logic [OFF_W-1:0]  r_off;
    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;
    logic              lk_hit, lk_hit_way, lk_vict_way, lk_vict_dirty;
    logic [TAG_W-1:0]  lk_vict_tag;
    logic [LINE_W-1:0] vict_line;
    logic              buf_full;
    logic              idle, acc, acc_hit, acc_miss, last_beat;

    logic [IDX_W-1:0]  f_idx;
    logic              f_way;
    logic [TAG_W-1:0]  f_tag;
    logic [OFF_W-1:0]  f_crit, f_cnt;
    logic [DATA_W-1:0] f_data;

    logic              wr_en, wr_way;
    logic [IDX_W-1:0]  wr_idx;
    logic [OFF_W-1:0]  wr_word;
    logic [DATA_W-1:0] wr_data;

    assign r_off = req_addr[OFF_W-1:0];
    assign r_idx = req_addr[OFF_W +: IDX_W];
    assign r_tag = req_addr[ADDR_W-1 -: TAG_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (acc_miss)  state_d = ST_FILL;
            ST_FILL: if (last_beat) state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath steering
    always_comb begin
        idle        = (state_q == ST_IDLE);
        req_ready   = idle && !(req_valid && !req_wt && !lk_hit && buf_full);
        acc         = req_valid && req_ready;
        acc_hit     = acc && lk_hit;
        acc_miss    = acc && !lk_hit && !req_wt;
        last_beat   = !idle && fill_valid && (f_cnt == OFF_W'(WORDS - 1));
        req_hit     = lk_hit;
        req_way     = lk_hit ? lk_hit_way : lk_vict_way;
        fill_req    = acc_miss;
        fill_addr   = req_addr;
        wt_valid    = acc && req_wt;
        wt_addr     = req_addr;
        wt_data     = req_data;
        flush_valid = idle && buf_full;
        if (idle) begin
            wr_en   = acc_hit;
            wr_idx  = r_idx;
            wr_way  = lk_hit_way;
            wr_word = r_off;
            wr_data = req_data;
        end else begin
            wr_en   = fill_valid;
            wr_idx  = f_idx;
            wr_way  = f_way;
            wr_word = f_crit + f_cnt;
            wr_data = (f_cnt == '0) ? f_data : fill_data;
        end
    end

    // miss context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_idx  <= '0;
            f_way  <= 1'b0;
            f_tag  <= '0;
            f_crit <= '0;
            f_cnt  <= '0;
            f_data <= '0;
        end else if (acc_miss) begin
            f_idx  <= r_idx;
            f_way  <= lk_vict_way;
            f_tag  <= r_tag;
            f_crit <= r_off;
            f_cnt  <= '0;
            f_data <= req_data;
        end else if (!idle && fill_valid) begin
            f_cnt  <= f_cnt + 1'b1;
        end
    end

    cbc_tag_dir #(.SETS(SETS), .TAG_W(TAG_W)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (r_idx),
        .lk_tag     (r_tag),
        .hit        (lk_hit),
        .hit_way    (lk_hit_way),
        .vict_way   (lk_vict_way),
        .vict_dirty (lk_vict_dirty),
        .vict_tag   (lk_vict_tag),
        .touch_en   (acc_hit),
        .touch_idx  (r_idx),
        .touch_way  (lk_hit_way),
        .dirty_en   (!req_wt),
        .inst_en    (last_beat),
        .inst_idx   (f_idx),
        .inst_way   (f_way),
        .inst_tag   (f_tag)
    );

    cbc_data_ram #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_way  (wr_way),
        .wr_word (wr_word),
        .wr_data (wr_data),
        .rd_idx  (r_idx),
        .rd_way  (lk_vict_way),
        .rd_line (vict_line)
    );

    cbc_evict_buf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (acc_miss && lk_vict_dirty),
        .load_addr ({lk_vict_tag, r_idx, {OFF_W{1'b0}}}),
        .load_line (vict_line),
        .drain_en  (flush_valid && flush_done),
        .full      (buf_full),
        .addr      (flush_addr),
        .line      (flush_line)
    );

    // R6: nothing is accepted while a fill is outstanding
    a_r6_no_accept_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> !req_ready);

    // R4: the parked line is not offered in the cycle after a fill request
    a_r4_flush_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> !flush_valid);

    // R10: a write-through store never asks for a fill
    a_r10_wt_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        wt_valid |-> !fill_req);

    // R8: a copy-back miss is held off while a line waits for write-back
    a_r8_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_wt && !req_hit && flush_valid) |-> !req_ready);

    // R5: the install cycle returns the controller to accepting requests
    a_r5_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> (state_q == ST_IDLE));
endmodule

// File: tb/cbc_store_ctrl_test.sv
module cbc_store_ctrl_test;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int SETS   = 4;
    localparam int WORDS  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_wt = 1'b0, fill_valid = 1'b0, flush_done = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0, fill_data = '0;
    logic req_ready, req_hit, req_way, fill_req, wt_valid, flush_valid;
    logic [ADDR_W-1:0] fill_addr, wt_addr, flush_addr;
    logic [DATA_W-1:0] wt_data;
    logic [WORDS*DATA_W-1:0] flush_line;

    always #2.5 clk = ~clk;

    cbc_store_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_wt(req_wt), .req_ready(req_ready), .req_hit(req_hit),
        .req_way(req_way), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data), .wt_valid(wt_valid),
        .wt_addr(wt_addr), .wt_data(wt_data), .flush_valid(flush_valid),
        .flush_addr(flush_addr), .flush_line(flush_line), .flush_done(flush_done)
    );

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    int mv[SETS][2], mm[SETS][2], mt[SETS][2], mru[SETS];
    logic [DATA_W-1:0] md[SETS][2][WORDS];
    bit busy = 0, bfull = 0, last_acc = 0;
    int beat, fcrit, fidx, fway, ftag;
    logic [DATA_W-1:0] fdat;
    logic [ADDR_W-1:0] baddr;
    logic [DATA_W-1:0] bline[WORDS];

    // expectations for the current cycle
    bit e_hit, e_ready, e_acc;
    int e_hw, e_vict, e_idx, e_tag, e_off;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int t, input int i, input int o);
        return ADDR_W'((t << 4) | (i << 2) | o);
    endfunction

    task automatic compute();
        e_off = int'(req_addr[1:0]);
        e_idx = int'(req_addr[3:2]);
        e_tag = int'(req_addr[7:4]);
        e_hit = 0;
        e_hw  = 0;
        for (int w = 0; w < 2; w++)
            if (mv[e_idx][w] != 0 && mt[e_idx][w] == e_tag) begin
                e_hit = 1;
                e_hw  = w;
            end
        if (mv[e_idx][0] == 0)      e_vict = 0;
        else if (mv[e_idx][1] == 0) e_vict = 1;
        else                        e_vict = 1 - mru[e_idx];
        e_ready = !busy && !(req_valid && !req_wt && !e_hit && bfull);
        e_acc   = req_valid && e_ready;
    endtask

    task automatic compare();
        string rq;
        bit e_fill, e_wt, e_flush;
        logic [WORDS*DATA_W-1:0] e_line;
        compute();
        rq = busy ? "R6" : ((req_valid && !req_wt && !e_hit && bfull) ? "R8" : "R7");
        chk(req_ready == e_ready, rq, "req_ready", 128'(req_ready), 128'(e_ready));
        if (req_valid && !busy) begin
            if (req_wt) rq = e_hit ? "R9" : "R10";
            else if (e_hit) rq = "R1";
            else rq = (mv[e_idx][0] != 0 && mv[e_idx][1] != 0) ? "R3" : "R2";
            chk(req_hit == e_hit, rq, "req_hit", 128'(req_hit), 128'(e_hit));
            chk(req_way == (e_hit ? e_hw[0] : e_vict[0]), rq, "req_way",
                128'(req_way), 128'(e_hit ? e_hw : e_vict));
        end
        e_fill = e_acc && !e_hit && !req_wt;
        chk(fill_req == e_fill, "R5", "fill_req", 128'(fill_req), 128'(e_fill));
        if (e_fill) chk(fill_addr == req_addr, "R5", "fill_addr", 128'(fill_addr), 128'(req_addr));
        e_wt = e_acc && req_wt;
        rq = e_hit ? "R9" : "R10";
        chk(wt_valid == e_wt, rq, "wt_valid", 128'(wt_valid), 128'(e_wt));
        if (e_wt) begin
            chk(wt_addr == req_addr, rq, "wt_addr", 128'(wt_addr), 128'(req_addr));
            chk(wt_data == req_data, rq, "wt_data", 128'(wt_data), 128'(req_data));
        end
        e_flush = bfull && !busy;
        chk(flush_valid == e_flush, "R4", "flush_valid", 128'(flush_valid), 128'(e_flush));
        if (e_flush) begin
            for (int k = 0; k < WORDS; k++) e_line[k*DATA_W +: DATA_W] = bline[k];
            chk(flush_addr == baddr, "R4", "flush_addr", 128'(flush_addr), 128'(baddr));
            chk(flush_line == e_line, "R4", "flush_line", 128'(flush_line), 128'(e_line));
        end
    endtask

    task automatic update();
        bit drain;
        int w;
        drain = bfull && !busy && flush_done;
        last_acc = 0;
        if (busy) begin
            if (fill_valid) begin
                w = (fcrit + beat) % WORDS;
                md[fidx][fway][w] = (beat == 0) ? fdat : fill_data;
                if (beat == WORDS - 1) begin
                    mv[fidx][fway] = 1;
                    mm[fidx][fway] = 1;
                    mt[fidx][fway] = ftag;
                    mru[fidx] = fway;
                    busy = 0;
                end
                beat++;
            end
        end else if (e_acc) begin
            last_acc = 1;
            if (e_hit) begin
                md[e_idx][e_hw][e_off] = req_data;
                mru[e_idx] = e_hw;
                if (!req_wt) mm[e_idx][e_hw] = 1;
            end else if (!req_wt) begin
                if (mv[e_idx][e_vict] != 0 && mm[e_idx][e_vict] != 0) begin
                    bfull = 1;
                    baddr = mk(mt[e_idx][e_vict], e_idx, 0);
                    for (int k = 0; k < WORDS; k++) bline[k] = md[e_idx][e_vict][k];
                end
                busy = 1; beat = 0; fcrit = e_off; fidx = e_idx;
                fway = e_vict; ftag = e_tag; fdat = req_data;
            end
        end
        if (drain) bfull = 0;
    endtask

    task automatic cycle();
        #1;
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    task automatic do_req(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit wt);
        req_valid = 1; req_addr = a; req_data = d; req_wt = wt;
        for (int g = 0; g < 40; g++) begin
            cycle();
            if (last_acc) break;
        end
        req_valid = 0;
    endtask

    task automatic feed(input logic [DATA_W-1:0] base);
        for (int k = 0; k < WORDS; k++) begin
            fill_valid = 1;
            fill_data = base + DATA_W'(k);
            cycle();
        end
        fill_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                mv[s][w] = 0; mm[s][w] = 0; mt[s][w] = 0;
                for (int k = 0; k < WORDS; k++) md[s][w][k] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R11: reset state
        chk(req_ready == 1'b1, "R11", "req_ready after reset", 128'(req_ready), 128'(1));
        chk(fill_req == 1'b0 && wt_valid == 1'b0 && flush_valid == 1'b0, "R11",
            "idle outputs after reset", 128'({fill_req, wt_valid, flush_valid}), 128'(0));
        @(negedge clk);
        cycle();

        // R2: both invalid, way 0 chosen; R6 stall probe during fill
        do_req(mk(1, 0, 2), 32'h11, 0);
        req_valid = 1; req_addr = mk(1, 0, 0); req_wt = 0; cycle(); req_valid = 0;
        feed(32'hA0);
        // R6: stray fill beat in idle
        fill_valid = 1; fill_data = 32'hDEAD; cycle(); fill_valid = 0;
        // R2: way 1 invalid
        do_req(mk(2, 0, 1), 32'h22, 0);
        feed(32'hB0);
        // R1: copy-back hit
        do_req(mk(1, 0, 2), 32'h33, 0);
        // R9: write-through hit
        do_req(mk(2, 0, 3), 32'h44, 1);
        // R10: write-through miss
        do_req(mk(5, 2, 0), 32'h55, 1);
        // R3 + R4: both valid, dirty victim parked
        do_req(mk(3, 0, 1), 32'h66, 0);
        feed(32'hC0);
        // R7: hit while parked line waits
        do_req(mk(2, 0, 0), 32'h78, 0);
        // R8: miss against full buffer
        req_valid = 1; req_addr = mk(4, 0, 0); req_data = 32'h88; req_wt = 0;
        repeat (3) cycle();
        flush_done = 1; cycle(); flush_done = 0;
        do_req(mk(4, 0, 0), 32'h88, 0);
        feed(32'hD0);
        // R7: hit in the same cycle as release
        flush_done = 1;
        do_req(mk(2, 0, 2), 32'h99, 0);
        flush_done = 0;
        cycle();
        // R5: wrap from critical word 3
        do_req(mk(6, 1, 3), 32'hAA, 0);
        feed(32'hE0);
        do_req(mk(7, 1, 3), 32'hBB, 0);
        feed(32'hF0);
        do_req(mk(8, 1, 0), 32'hCC, 0);
        feed(32'h100);
        cycle();
        flush_done = 1; cycle(); flush_done = 0;
        repeat (3) cycle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule